// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is one I/O cell of a small programmable logic device. The product-term array sits outside the cell and presents its product terms as an input vector. The cell ORs those terms into a sum. The sum goes out either through a D flip-flop or straight to the pad. The cell also builds its own output-enable term from the cell's true and complement input literals, under a connection mask.

A separate select chooses the signal returned to the array. It can be the pad level, the flip-flop output or the raw sum, and this choice does not depend on the output mode. With no enable connections kept, the cell is a dedicated output. With every connection kept, each literal meets its own complement, so the enable is always false and the pad is a dedicated input. Configuration arrives as static inputs.

Top module: `pld_io_cell`

## Requirements
- R1: The sum output is the OR of all bits of `pt_i`. It is 0 only when every bit of `pt_i` is 0.
- R2: On each rising clock edge the flip-flop loads the sum. If `sync_clr_i` is 1 at that edge, the flip-flop loads 0 instead.
- R3: While the enable is true, `pin_o` equals the flip-flop output when `reg_mode_i` is 1. It equals the sum when `reg_mode_i` is 0.
- R4: The literals are numbered as follows:
  - Literal k is `oe_in_i[k]`.
  - Literal N_IN+k is the inverse of `oe_in_i[k]`.

  The enable is the AND of every literal whose `oe_conn_i` bit is 1. When `oe_conn_i` is all zeros, the enable is 1.
- R5: When `oe_conn_i` is all ones, `pin_oe_o` is 0 for every input pattern.
- R6: `fb_sel_i` selects the source of `fb_o`:
  - 00 selects `pin_i`.
  - 01 selects the flip-flop output.
  - 10 selects the sum.
  - The reserved code 11 selects `pin_i`.
- R7: Flip-flop and sum feedback do not depend on `reg_mode_i` or on the enable. This holds while the pad is disabled.
- R8: While `pin_oe_o` is 0, `pin_o` is 0.
- R9: When `rst_ni` goes low, the flip-flop clears to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Flip-flop clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_clr_i | input | 1 | Synchronous clear of the flip-flop |
| pt_i | input | N_TERMS | Product terms feeding the OR gate |
| oe_in_i | input | N_IN | Inputs whose true and complement literals form the enable term |
| oe_conn_i | input | 2*N_IN | Connection mask; 1 means the literal is kept in the enable AND |
| reg_mode_i | input | 1 | 1 selects registered output, 0 selects combinatorial |
| fb_sel_i | input | 2 | Feedback source select |
| pin_i | input | 1 | Level seen at the pad |
| pin_o | output | 1 | Data driven toward the pad |
| pin_oe_o | output | 1 | Pad driver enable |
| fb_o | output | 1 | Feedback returned to the array |

## Verification
The sweep walks every combination of product terms, enable inputs, connection masks, feedback codes, output modes and pad levels. It steps the flip-flop on each cycle and clears it now and then, so stale register state is always on show.

- The empty and full connection masks are the two enable corners. A design that treats an empty mask as false would leave a dedicated output undriven. One that ignores the complement literals would drive a dedicated input.
- The reserved feedback code catches a decoder that falls through to the register or to the sum.
- Disabled-pad cases with flip-flop and sum feedback catch a feedback path that was wrongly taken after the output gating.
- A reset pulse between clock edges catches a reset that was made synchronous.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;
  typedef enum logic [1:0] {
    FB_PIN = 2'b00,
    FB_REG = 2'b01,
    FB_SUM = 2'b10,
    FB_RSV = 2'b11
  } fb_sel_e;
endpackage

// File: rtl/pld_sum_term.sv
module pld_sum_term #(
  parameter int N_TERMS = 4
) (
  input  logic [N_TERMS-1:0] pt_i,
  output logic               sum_o
);
  assign sum_o = |pt_i;
endmodule

// File: rtl/pld_oe_term.sv
module pld_oe_term #(
  parameter int N_IN = 2,
  localparam int N_LIT = 2 * N_IN
) (
  input  logic [N_IN-1:0]  in_i,
  input  logic [N_LIT-1:0] conn_i,
  output logic             oe_o
);
  logic [N_LIT-1:0] lit;
  logic [N_LIT-1:0] kept;

  for (genvar k = 0; k < N_IN; k++) begin : g_lit
    assign lit[k]      = in_i[k];
    assign lit[N_IN+k] = ~in_i[k];
  end

  // an open connection contributes a 1 to the AND
  for (genvar j = 0; j < N_LIT; j++) begin : g_kept
    assign kept[j] = lit[j] | ~conn_i[j];
  end

  assign oe_o = &kept;
endmodule

// File: rtl/pld_cell_ff.sv
module pld_cell_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else            q_o <= d_i;
  end
endmodule

// File: rtl/pld_io_cell.sv
module pld_io_cell
  import pld_cell_pkg::*;
#(
  parameter int N_TERMS = 4,
  parameter int N_IN    = 2,
  localparam int N_LIT  = 2 * N_IN
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_clr_i,
  input  logic [N_TERMS-1:0] pt_i,
  input  logic [N_IN-1:0]    oe_in_i,
  input  logic [N_LIT-1:0]   oe_conn_i,
  input  logic               reg_mode_i,
  input  logic [1:0]         fb_sel_i,
  input  logic               pin_i,
  output logic               pin_o,
  output logic               pin_oe_o,
  output logic               fb_o
);
  logic    cell_sum;
  logic    cell_q;
  logic    cell_oe;
  logic    out_data;
  fb_sel_e fb_sel;

  pld_sum_term #(.N_TERMS(N_TERMS)) i_sum (
    .pt_i  (pt_i),
    .sum_o (cell_sum)
  );

  pld_oe_term #(.N_IN(N_IN)) i_oe (
    .in_i   (oe_in_i),
    .conn_i (oe_conn_i),
    .oe_o   (cell_oe)
  );

  pld_cell_ff i_ff (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sync_clr_i),
    .d_i    (cell_sum),
    .q_o    (cell_q)
  );

  assign out_data = reg_mode_i ? cell_q : cell_sum;
  assign pin_oe_o = cell_oe;
  assign pin_o    = out_data & cell_oe;

  // feedback is taken ahead of output gating
  assign fb_sel = fb_sel_e'(fb_sel_i);
  always_comb begin
    case (fb_sel)
      FB_REG:  fb_o = cell_q;
      FB_SUM:  fb_o = cell_sum;
      default: fb_o = pin_i;
    endcase
  end
endmodule

// File: rtl/pld_io_cell_chk.sv
module pld_io_cell_chk #(
  parameter int N_TERMS = 4,
  parameter int N_IN    = 2,
  localparam int N_LIT  = 2 * N_IN
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sync_clr_i,
  input logic [N_TERMS-1:0] pt_i,
  input logic [N_LIT-1:0]   oe_conn_i,
  input logic               reg_mode_i,
  input logic [1:0]         fb_sel_i,
  input logic               pin_i,
  input logic               pin_o,
  input logic               pin_oe_o,
  input logic               fb_o,
  input logic               cell_q,
  input logic               cell_sum
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_sum_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_i == '0) |-> !cell_sum);

  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (cell_q == ($past(sync_clr_i) ? 1'b0 : $past(cell_sum))));

  p_reg_out_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o && reg_mode_i) |-> (pin_o == cell_q));

  p_oe_open_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_conn_i == '0) |-> pin_oe_o);

  p_oe_closed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&oe_conn_i) |-> !pin_oe_o);

  p_fb_pin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_sel_i == 2'b00 || fb_sel_i == 2'b11) |-> (fb_o == pin_i));

  p_fb_int_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_sel_i == 2'b01) |-> (fb_o == cell_q));

  p_fb_sum_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_sel_i == 2'b10) |-> (fb_o == cell_sum));

  p_pin_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_oe_o |-> !pin_o);

  p_comb_out_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o && !reg_mode_i) |-> (pin_o == cell_sum));
endmodule

bind pld_io_cell pld_io_cell_chk #(.N_TERMS(N_TERMS), .N_IN(N_IN)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sync_clr_i (sync_clr_i),
  .pt_i       (pt_i),
  .oe_conn_i  (oe_conn_i),
  .reg_mode_i (reg_mode_i),
  .fb_sel_i   (fb_sel_i),
  .pin_i      (pin_i),
  .pin_o      (pin_o),
  .pin_oe_o   (pin_oe_o),
  .fb_o       (fb_o),
  .cell_q     (cell_q),
  .cell_sum   (cell_sum)
);

// File: tb/test_pld_io_cell.sv
module test_pld_io_cell;
  localparam int N_TERMS = 4;
  localparam int N_IN    = 2;
  localparam int N_LIT   = 2 * N_IN;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               sync_clr_i = 1'b0;
  logic [N_TERMS-1:0] pt_i = '0;
  logic [N_IN-1:0]    oe_in_i = '0;
  logic [N_LIT-1:0]   oe_conn_i = '0;
  logic               reg_mode_i = 1'b0;
  logic [1:0]         fb_sel_i = 2'b00;
  logic               pin_i = 1'b0;
  logic               pin_o, pin_oe_o, fb_o;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;
  logic mq;

  always #5ns clk_i = ~clk_i;

  pld_io_cell #(.N_TERMS(N_TERMS), .N_IN(N_IN)) i_pld_io_cell (
    .clk_i, .rst_ni, .sync_clr_i, .pt_i, .oe_in_i, .oe_conn_i,
    .reg_mode_i, .fb_sel_i, .pin_i, .pin_o, .pin_oe_o, .fb_o
  );

  // reference flip-flop
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mq <= 1'b0;
    else if (sync_clr_i) mq <= 1'b0;
    else                 mq <= |pt_i;
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_oe(input logic [N_IN-1:0] in, input logic [N_LIT-1:0] conn);
    logic r = 1'b1;
    for (int k = 0; k < N_IN; k++) begin
      if (conn[k])      r &= in[k];
      if (conn[N_IN+k]) r &= ~in[k];
    end
    return r;
  endfunction

  task automatic check_all();
    logic s = |pt_i;
    logic oe = exp_oe(oe_in_i, oe_conn_i);
    logic d = reg_mode_i ? mq : s;
    logic f;
    case (fb_sel_i)
      2'b01:   f = mq;
      2'b10:   f = s;
      default: f = pin_i;
    endcase
    if (oe_conn_i == '0)      check("R4 open mask", pin_oe_o, 1'b1);
    else if (&oe_conn_i)      check("R5 full mask", pin_oe_o, 1'b0);
    else                      check("R4 enable", pin_oe_o, oe);
    if (!oe)                  check("R8 gated pin", pin_o, 1'b0);
    else if (reg_mode_i)      check("R3 reg pin", pin_o, d);
    else                      check("R1 R3 comb pin", pin_o, d);
    if (fb_sel_i == 2'b11)    check("R6 reserved fb", fb_o, f);
    else if (fb_sel_i == 2'b00) check("R6 pin fb", fb_o, f);
    else                      check("R7 internal fb", fb_o, f);
  endtask

  initial begin
    #5ms;
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int it = 0;
    #12ns;
    fb_sel_i = 2'b01;
    #1ns;
    check("R9 reset state fb", fb_o, 1'b0);
    check("R4 reset state oe", pin_oe_o, 1'b1);
    check("R8 reset state pin", pin_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 directed capture and clear
    @(negedge clk_i);
    pt_i = 4'b0100; fb_sel_i = 2'b01; reg_mode_i = 1'b1;
    @(negedge clk_i); #1ns;
    check("R2 capture one", fb_o, 1'b1);
    check("R3 reg pin one", pin_o, 1'b1);
    sync_clr_i = 1'b1;
    @(negedge clk_i); #1ns;
    check("R2 sync clear", fb_o, 1'b0);
    sync_clr_i = 1'b0;
    @(negedge clk_i); #1ns;
    check("R2 recapture", fb_o, 1'b1);
    pt_i = '0;
    @(negedge clk_i); #1ns;
    check("R2 capture zero", fb_o, 1'b0);

    // R7 with pad disabled: sum and register still fed back
    pt_i = 4'b0001; oe_conn_i = '1;
    @(negedge clk_i); #1ns;
    check("R7 reg fb while disabled", fb_o, 1'b1);
    fb_sel_i = 2'b10; pt_i = '0; #1ns;
    check("R7 sum fb while disabled", fb_o, 1'b0);
    check("R8 disabled pin", pin_o, 1'b0);

    // exhaustive sweep
    for (int m = 0; m < 2; m++)
      for (int fs = 0; fs < 4; fs++)
        for (int c = 0; c < (1 << N_LIT); c++)
          for (int ii = 0; ii < (1 << N_IN); ii++)
            for (int p = 0; p < (1 << N_TERMS); p++)
              for (int pv = 0; pv < 2; pv++) begin
                @(negedge clk_i);
                reg_mode_i = m[0];
                fb_sel_i   = fs[1:0];
                oe_conn_i  = c[N_LIT-1:0];
                oe_in_i    = ii[N_IN-1:0];
                pt_i       = N_TERMS'((p + it) % (1 << N_TERMS));
                pin_i      = pv[0];
                sync_clr_i = (it % 11 == 5);
                it++;
                #1ns;
                check_all();
              end
    sync_clr_i = 1'b0;

    // R9 asynchronous reset between edges
    @(negedge clk_i);
    pt_i = 4'b1000; fb_sel_i = 2'b01; oe_conn_i = '0;
    @(negedge clk_i); #1ns;
    check("R9 preload", fb_o, 1'b1);
    #1ns rst_ni = 1'b0;
    #1ns;
    check("R9 async clear", fb_o, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule